// File: doc/BRIEF.md
# I2S Bit and Frame Clock Generator

This block produces the serial bit clock and the word-select (frame) clock of an I2S link from a master system clock, with one independent channel for the transmit direction and one for the receive direction. Every frame holds 64 bit-clock periods. The ratio of master clock to frame clock can be set to 256, 384, 512 or 768 by a divider code equal to ratio/64 minus one, so one bit-clock period lasts code+1 master clocks. The channel outputs are single-cycle enables for the serial logic in the master clock domain, together with pin-level clock waveforms and their output enables.

Software writes a divider code to a channel with a one-cycle write strobe. The channel checks the code and drops an illegal one, raising a reject pulse. A legal code waits in a holding register and is applied only at the end of a frame, so a rate change never produces a clipped bit-clock pulse. A shared run control starts and stops the bit clock, and a stop always completes the current bit period first. In master mode the channel drives its bit clock and word select out. In slave mode it releases the pins, synchronizes the external clocks and derives its enables from them. The master clock can be gated onto a pin.

Top module: `i2s_clk_gen`

## Requirements
- R1: With divider code D applied in master mode, consecutive `bit_en` pulses are D+1 clocks apart. Each bit period has (D+1)/2 low clocks of `bclk_o` followed by the remaining high clocks.
- R2: A code written with `div_wr` is legal only if it is 3, 5, 7 or 11. Any other code sets `div_rej` for exactly one cycle, starting the cycle after the write, and leaves the divider unchanged.
- R3: Index 0 of every per-direction port is the transmit channel and index 1 is the receive channel. Each index keeps its own divider.
- R4: A frame is 64 bit periods. `ws_o` is low for bits 0 to 31 and high for bits 32 to 63, and it changes only while `bclk_o` is low. `frame_start` accompanies the `bit_en` of bit 0.
- R5: A legal code written while the clock runs does not change the current frame. It takes effect from bit 0 of the next frame.
- R6: When `run` goes low, the clock stops at the end of the current bit period and then holds `bclk_o`, `ws_o` and `bit_en` low. A restart begins at bit 0, with `frame_start`.
- R7: When `master_mode` is 0, `pin_oe` is 0 and `bclk_o` and `ws_o` are held low. `bit_en` then pulses once for each rising edge of the synchronized `bclk_in`, and `frame_start` pulses on the first such edge that sees `ws_in` low after an edge that saw it high.
- R8: `mclk_o` follows `clk` while `mclk_en` is 1 and is low otherwise. The gate changes only on falling edges of `clk`.
- R9: After reset both dividers hold code 3 and the clocks are stopped with all outputs low.
- R10: In master mode, `bit_en` is a one-cycle pulse in the first cycle in which `bclk_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run | input | 1 | Bit clock start (1) / stop (0), shared by both channels |
| master_mode | input | 1 | 1: drive bit clock and word select; 0: take them from pins |
| mclk_en | input | 1 | Gate the master clock onto `mclk_o` |
| div_wr | input | 2 | Divider write strobe per channel |
| div_data | input | 2x4 | Divider code per channel |
| bclk_in | input | 2 | External bit clock per channel (slave mode) |
| ws_in | input | 2 | External word select per channel (slave mode) |
| bclk_o | output | 2 | Bit clock pin level per channel |
| ws_o | output | 2 | Word select pin level per channel |
| pin_oe | output | 2 | Output enable for the bit clock and word select pins |
| bit_en | output | 2 | One-cycle enable at each bit clock rising edge |
| frame_start | output | 2 | One-cycle mark on bit 0 of a frame |
| div_rej | output | 2 | One-cycle pulse after an illegal divider write |
| mclk_o | output | 1 | Gated master clock pin |

## Verification
The assertions check several rules on every cycle. A master `bit_en` must land on a fresh rising edge of `bclk_o`. The word select may move only while the bit clock is low, and a frame mark must come with the word select low. A reject pulse must follow a write, and after a stop request the bit clock must not rise again once it has fallen. Other behaviours need the bench's scenarios, because they depend on measured distances or on what happened earlier. These are the exact bit and frame period for each divider code, the choice between accepting and refusing codes, the divider change waiting for the frame boundary, the restart at bit 0, the counts of edges taken from external pins in slave mode, and the master clock gate.

// File: rtl/i2s_clk_pkg.sv
package i2s_clk_pkg;
  localparam int DIV_W = 4;
  localparam int NDIR  = 2;
  typedef logic [DIV_W-1:0] div_t;
  localparam div_t DIV_RESET = div_t'(3);

  // legal codes correspond to master/frame ratios 256, 384, 512, 768
  function automatic logic div_legal(div_t v);
    return (v == div_t'(3)) || (v == div_t'(5)) ||
           (v == div_t'(7)) || (v == div_t'(11));
  endfunction
endpackage

// File: rtl/i2s_sync2.sv
module i2s_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= 1'b0;
      q    <= 1'b0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/i2s_div_chan.sv
module i2s_div_chan
  import i2s_clk_pkg::*;
#(
  parameter int FRAME_BITS = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic master,
  input  logic div_wr,
  input  div_t div_data,
  input  logic bclk_in,
  input  logic ws_in,
  output logic bclk_o,
  output logic ws_o,
  output logic pin_oe,
  output logic bit_en,
  output logic frame_start,
  output logic div_rej
);
  localparam int CNT_W = $clog2(FRAME_BITS);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(FRAME_BITS - 1);

  div_t pend_div, cur_div, ph, half;
  logic [CNT_W-1:0] bitn;
  logic running, go, bit_end, frame_end;
  logic m_bit, m_bclk, m_ws;

  assign go        = run && master;
  assign half      = div_t'(({1'b0, cur_div} + 1'b1) >> 1);
  assign bit_end   = running && (ph == cur_div);
  assign frame_end = bit_end && (bitn == LAST_BIT);

  // divider holding register and the reject pulse
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_div <= DIV_RESET;
      div_rej  <= 1'b0;
    end else begin
      div_rej <= div_wr && !div_legal(div_data);
      if (div_wr && div_legal(div_data)) pend_div <= div_data;
    end
  end

  // active divider: moves only while stopped or at the end of a frame
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur_div <= DIV_RESET;
    else if (!running || frame_end) cur_div <= pend_div;
  end

  // phase and bit counters; a stop is honoured only at a bit end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      ph      <= '0;
      bitn    <= '0;
    end else if (!running) begin
      running <= go;
      ph      <= '0;
      bitn    <= '0;
    end else if (bit_end) begin
      ph   <= '0;
      bitn <= bitn + 1'b1;
      if (!go) running <= 1'b0;
    end else begin
      ph <= ph + 1'b1;
    end
  end

  assign m_bclk = running && (ph >= half);
  assign m_ws   = running && bitn[CNT_W-1];
  assign m_bit  = running && (ph == half);

  // slave path: synchronized pins and edge detection
  logic bs, wss, bs_p, ws_cap, s_bit, s_frame;

  i2s_sync2 u_sync_bclk (.clk(clk), .rst_n(rst_n), .d(bclk_in), .q(bs));
  i2s_sync2 u_sync_ws   (.clk(clk), .rst_n(rst_n), .d(ws_in),   .q(wss));

  assign s_bit   = bs && !bs_p;
  assign s_frame = s_bit && !wss && ws_cap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bs_p   <= 1'b0;
      ws_cap <= 1'b0;
    end else begin
      bs_p <= bs;
      if (s_bit) ws_cap <= wss;
    end
  end

  assign pin_oe      = master;
  assign bclk_o      = master && m_bclk;
  assign ws_o        = master && m_ws;
  assign bit_en      = master ? m_bit : s_bit;
  assign frame_start = master ? (m_bit && (bitn == '0)) : s_frame;
endmodule

// File: rtl/i2s_clk_gen.sv
module i2s_clk_gen
  import i2s_clk_pkg::*;
#(
  parameter int FRAME_BITS = 64
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       run,
  input  logic                       master_mode,
  input  logic                       mclk_en,
  input  logic [NDIR-1:0]            div_wr,
  input  logic [NDIR-1:0][DIV_W-1:0] div_data,
  input  logic [NDIR-1:0]            bclk_in,
  input  logic [NDIR-1:0]            ws_in,
  output logic [NDIR-1:0]            bclk_o,
  output logic [NDIR-1:0]            ws_o,
  output logic [NDIR-1:0]            pin_oe,
  output logic [NDIR-1:0]            bit_en,
  output logic [NDIR-1:0]            frame_start,
  output logic [NDIR-1:0]            div_rej,
  output logic                       mclk_o
);
  for (genvar d = 0; d < NDIR; d++) begin : g_chan
    i2s_div_chan #(.FRAME_BITS(FRAME_BITS)) u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .run        (run),
      .master     (master_mode),
      .div_wr     (div_wr[d]),
      .div_data   (div_data[d]),
      .bclk_in    (bclk_in[d]),
      .ws_in      (ws_in[d]),
      .bclk_o     (bclk_o[d]),
      .ws_o       (ws_o[d]),
      .pin_oe     (pin_oe[d]),
      .bit_en     (bit_en[d]),
      .frame_start(frame_start[d]),
      .div_rej    (div_rej[d])
    );
  end

  // gate enable changes while clk is low, so the pin never gets a runt pulse
  logic mclk_gate;
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) mclk_gate <= 1'b0;
    else        mclk_gate <= mclk_en;
  end
  assign mclk_o = clk & mclk_gate;
endmodule

// File: rtl/i2s_clk_gen_chk.sv
module i2s_clk_gen_chk
  import i2s_clk_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       run,
  input logic                       master_mode,
  input logic [NDIR-1:0]            div_wr,
  input logic [NDIR-1:0]            bclk_o,
  input logic [NDIR-1:0]            ws_o,
  input logic [NDIR-1:0]            bit_en,
  input logic [NDIR-1:0]            frame_start,
  input logic [NDIR-1:0]            div_rej
);
  for (genvar d = 0; d < NDIR; d++) begin : g_chk
    assert_bit_en_rise_R10: assert property (@(posedge clk) disable iff (!rst_n)
      master_mode && $past(master_mode) && bit_en[d] |-> bclk_o[d] && !$past(bclk_o[d]));

    assert_ws_moves_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      master_mode && $past(master_mode) && (ws_o[d] != $past(ws_o[d])) |-> !bclk_o[d]);

    assert_frame_ws_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
      master_mode && $past(master_mode) && frame_start[d] |-> !ws_o[d] && bit_en[d]);

    assert_rej_follows_wr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      div_rej[d] |-> $past(div_wr[d]));

    assert_stop_holds_R6: assert property (@(posedge clk) disable iff (!rst_n)
      master_mode && $past(master_mode) && !run && !$past(run) && $fell(bclk_o[d])
      |=> !bclk_o[d]);
  end
endmodule

bind i2s_clk_gen i2s_clk_gen_chk u_chk (
  .clk(clk), .rst_n(rst_n), .run(run), .master_mode(master_mode),
  .div_wr(div_wr), .bclk_o(bclk_o), .ws_o(ws_o), .bit_en(bit_en),
  .frame_start(frame_start), .div_rej(div_rej)
);

// File: tb/i2s_clk_gen_tb.sv
module i2s_clk_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 10;
  // {dir, code[3:0], reject, period[5:0]}
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 4'd5,  1'b0, 6'd6},
    {1'b0, 4'd7,  1'b0, 6'd8},
    {1'b0, 4'd11, 1'b0, 6'd12},
    {1'b0, 4'd4,  1'b1, 6'd12},
    {1'b0, 4'd0,  1'b1, 6'd12},
    {1'b0, 4'd3,  1'b0, 6'd4},
    {1'b1, 4'd11, 1'b0, 6'd12},
    {1'b1, 4'd9,  1'b1, 6'd12},
    {1'b1, 4'd15, 1'b1, 6'd12},
    {1'b1, 4'd5,  1'b0, 6'd6}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic master_mode = 1'b1;
  logic mclk_en = 1'b0;
  logic [1:0] div_wr = '0;
  logic [1:0][3:0] div_data = '0;
  logic [1:0] bclk_in = '0;
  logic [1:0] ws_in = '0;
  logic [1:0] bclk_o, ws_o, pin_oe, bit_en, frame_start, div_rej;
  logic mclk_o;
  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2s_clk_gen u_dut (
    .clk(clk), .rst_n(rst_n), .run(run), .master_mode(master_mode),
    .mclk_en(mclk_en), .div_wr(div_wr), .div_data(div_data),
    .bclk_in(bclk_in), .ws_in(ws_in), .bclk_o(bclk_o), .ws_o(ws_o),
    .pin_oe(pin_oe), .bit_en(bit_en), .frame_start(frame_start),
    .div_rej(div_rej), .mclk_o(mclk_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_bit(input int d, output int c);
    c = 0;
    do begin @(negedge clk); c++; end while (!bit_en[d] && c < 400);
  endtask

  task automatic wait_frame(input int d, output int c);
    c = 0;
    do begin @(negedge clk); c++; end while (!frame_start[d] && c < 4000);
  endtask

  task automatic write_div(input int d, input int code);
    div_wr[d] = 1'b1;
    div_data[d] = 4'(code);
    @(negedge clk);
    div_wr[d] = 1'b0;
  endtask

  initial begin
    repeat (CLK_PERIOD * 20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    int c;
    int hi;
    int nb;
    int nf;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R9: stopped, quiet outputs, default divider 3 -> period 4
    check("R9 bclk idle", int'(bclk_o), 0);
    check("R9 ws idle", int'(ws_o), 0);
    check("R9 bit_en idle", int'(bit_en), 0);
    run = 1'b1;
    wait_bit(0, c);
    wait_bit(0, c);
    check("R9 default tx period", c, 4);
    wait_bit(1, c);
    wait_bit(1, c);
    check("R9 default rx period", c, 4);

    // table walk: R1 periods, R2 legality, R3 per-direction dividers
    for (int i = 0; i < NV; i++) begin
      int d;
      d = int'(VEC[i][11]);
      run = 1'b0;
      repeat (20) @(negedge clk);
      write_div(d, int'(VEC[i][10:7]));
      check("R2 reject pulse", int'(div_rej[d]), int'(VEC[i][6]));
      @(negedge clk);
      check("R2 reject one cycle", int'(div_rej[d]), 0);
      repeat (2) @(negedge clk);
      run = 1'b1;
      wait_bit(d, c);
      wait_bit(d, c);
      check("R1 bit period", c, int'(VEC[i][5:0]));
    end
    wait_bit(0, c);
    wait_bit(0, c);
    check("R3 tx keeps own divider", c, 4);
    wait_bit(1, c);
    wait_bit(1, c);
    check("R3 rx keeps own divider", c, 6);

    // R4: word select and frame length (tx code 3)
    wait_frame(0, c);
    check("R4 ws low at frame start", int'(ws_o[0]), 0);
    for (int k = 1; k <= 31; k++) wait_bit(0, c);
    check("R4 ws low at bit 31", int'(ws_o[0]), 0);
    wait_bit(0, c);
    check("R4 ws high at bit 32", int'(ws_o[0]), 1);
    wait_frame(0, c);
    check("R4 half frame to next start", c, 128);
    wait_frame(0, c);
    check("R4 frame length", c, 256);

    // R5: write mid-frame, applied at next frame
    for (int k = 0; k < 5; k++) wait_bit(0, c);
    write_div(0, 7);
    wait_bit(0, c);
    wait_bit(0, c);
    check("R5 old divider until frame end", c, 4);
    wait_frame(0, c);
    wait_bit(0, c);
    check("R5 new divider after boundary", c, 8);

    // R1 / R10: low/high split for code 7 and pulse on first high cycle
    wait_bit(0, c);
    check("R10 bclk high at bit_en", int'(bclk_o[0]), 1);
    hi = 0;
    while (bclk_o[0] && hi < 50) begin hi++; @(negedge clk); end
    check("R1 high clocks per bit", hi, 4);

    // R6: stop and restart
    run = 1'b0;
    repeat (14) @(negedge clk);
    nb = 0;
    for (int k = 0; k < 30; k++) begin
      if (bclk_o[0] || bit_en[0] || ws_o[0]) nb++;
      @(negedge clk);
    end
    check("R6 held low after stop", nb, 0);
    run = 1'b1;
    wait_bit(0, c);
    check("R6 restart at bit 0", int'(frame_start[0]), 1);

    // R7: slave mode from external pins
    master_mode = 1'b0;
    repeat (20) @(negedge clk);
    check("R7 pins released", int'(pin_oe[0]), 0);
    check("R7 bclk not driven", int'(bclk_o[0]), 0);
    nb = 0;
    nf = 0;
    for (int b = 0; b < 70; b++) begin
      ws_in[0] = (b < 16 || b >= 48);
      for (int p = 0; p < 10; p++) begin
        if (bit_en[0]) nb++;
        if (frame_start[0]) nf++;
        bclk_in[0] = (p >= 5);
        @(negedge clk);
      end
    end
    bclk_in[0] = 1'b0;
    for (int p = 0; p < 6; p++) begin
      if (bit_en[0]) nb++;
      if (frame_start[0]) nf++;
      @(negedge clk);
    end
    check("R7 slave bit edges", nb, 70);
    check("R7 slave frame marks", nf, 1);
    check("R7 slave ws not driven", int'(ws_o[0]), 0);
    master_mode = 1'b1;

    // R8: master clock gate
    @(posedge clk);
    #1 check("R8 mclk gated off", int'(mclk_o), 0);
    @(posedge clk);
    mclk_en = 1'b1;
    @(posedge clk);
    #1 check("R8 mclk high phase", int'(mclk_o), 1);
    @(negedge clk);
    #1 check("R8 mclk low phase", int'(mclk_o), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule